// File: doc/BRIEF.md
# Nibble RAM Pointer Unit

This block owns the data-memory pointer of a 4-bit controller core. It holds a 7-bit pointer split into a 3-bit row and a 4-bit digit, contains the 128-nibble data RAM, and carries out every instruction that reads or writes that RAM or moves the pointer. These are: loads, exchanges, exchanges that step the digit up or down, immediate stores, direct-address loads and exchanges, single-bit set and clear, and copies between the accumulator and the pointer.

The core's sequencer presents one executed instruction per cycle on `op_valid`, with its first byte on `op_code`, the second byte (when the instruction has one) on `op_arg`, and the current accumulator on `a_in`. One cycle later the block returns the new accumulator value on `a_out` with `a_load` high when the accumulator is to be replaced. It raises `skip_req` when the instruction asks the sequencer to skip the next one. Pointer-load instructions that follow one another directly are ignored after the first, so a table of alternative entry points made of such loads works as intended.

Top module: `nib_ptr_unit`

## Requirements
- R1: A synchronous high `rst` sets the pointer to 0, `a_out` to 0, drops `a_load` and `skip_req`, and clears the repeated-load memory, so the first pointer load after reset takes effect.
- R2: Opcode 00rr0101 puts RAM[pointer] in the accumulator and then XORs the 2-bit r into the low two bits of the row; the digit is unchanged.
- R3: Opcode 00rr0110 swaps the accumulator with RAM[pointer], then XORs r into the row.
- R4: Opcode 00rr0100 swaps the accumulator with RAM[pointer], adds 1 to the digit modulo 16 and XORs r into the row; `skip_req` is raised exactly when the digit goes from 15 to 0.
- R5: Opcode 00rr0111 swaps the accumulator with RAM[pointer], subtracts 1 from the digit modulo 16 and XORs r into the row; `skip_req` is raised exactly when the digit goes from 0 to 15.
- R6: Opcode 0111yyyy writes y into RAM[pointer] and adds 1 to the digit modulo 16 with the row kept, and never raises `skip_req`, even on wraparound.
- R7: Opcode 00rr1ddd sets the row to 0rr and the digit to (1ddd + 1) mod 16. The pair 0x33, 1rrrdddd loads the pointer with the low 7 bits of the second byte, and 0x33 followed by a second byte with bit 7 clear leaves the pointer alone.
- R8: A pointer load (either form of R7) that directly follows another pointer load in the instruction stream has no effect; any other valid instruction, including one this block does not act on, ends the run, and idle cycles do not end it.
- R9: The pair 0x23, 1rrrdddd swaps the accumulator with RAM[rrrdddd]; 0x23, 0rrrdddd loads the accumulator from RAM[rrrdddd]; neither moves the pointer.
- R10: Opcodes 0x4C, 0x45, 0x42, 0x43 clear bit 0, 1, 2, 3 of RAM[pointer]; 0x4D, 0x47, 0x46, 0x4B set bit 0, 1, 2, 3; other bits and the pointer are kept.
- R11: 0x50 copies the accumulator into the digit; 0x4E returns the digit as the new accumulator.
- R12: 0x12 makes the row {0, a_in[1:0]} and returns the old row, zero-extended to 4 bits, as the new accumulator.
- R13: Results appear on the outputs one clock after the instruction; `a_load` and `skip_req` are high for that cycle only; `a_out` holds its value when `a_load` is low; with `op_valid` low nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An executed instruction is present this cycle |
| op_code | input | 8 | First instruction byte |
| op_arg | input | 8 | Second instruction byte, used by 0x23 and 0x33 |
| a_in | input | 4 | Current accumulator |
| a_out | output | 4 | New accumulator value, held between loads |
| a_load | output | 1 | Accumulator is to take `a_out` this cycle |
| skip_req | output | 1 | Skip the following instruction |
| b_out | output | 7 | Pointer, row in bits 6:4, digit in bits 3:0 |

## Verification
The step-and-exchange instructions fold three effects into one edge: a RAM read, a RAM write of the same address, and a pointer change of both digit and row, with a wrap skip raised on top. The bench provokes this by setting the digit to 15 or 0 with a nonzero row field and a known RAM word, then judges the returned nibble, the new digit, the flipped row and `skip_req` together in the one result cycle. The second overlap is the repeated-load suppression meeting a run-ending instruction: loads are placed back to back, across idle cycles, and around a foreign opcode, and each outcome is read from `b_out`.

// File: rtl/nptr_pkg.sv
package nptr_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_LD,
    K_XCH,
    K_XINC,
    K_XDEC,
    K_STORE,
    K_PLD_S,
    K_PLD_L,
    K_DXCH,
    K_DLD,
    K_BCLR,
    K_BSET,
    K_A2D,
    K_D2A,
    K_XROW
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] rsel;
    logic [3:0] imm;
    logic [1:0] bsel;
    logic [6:0] dir;
  } dec_t;

endpackage

// File: rtl/nptr_decode.sv
module nptr_decode
  import nptr_pkg::*;
(
  input  logic [7:0] op_code,
  input  logic [7:0] op_arg,
  output dec_t       dec
);

  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    dec.rsel = op_code[5:4];
    dec.imm  = op_code[3:0];
    dec.dir  = op_arg[6:0];
    if (op_code == 8'h33) begin
      dec.kind = op_arg[7] ? K_PLD_L : K_NONE;
    end else if (op_code == 8'h23) begin
      dec.kind = op_arg[7] ? K_DXCH : K_DLD;
    end else if (op_code == 8'h12) begin
      dec.kind = K_XROW;
    end else if (op_code[7:6] == 2'b00 && op_code[3]) begin
      dec.kind = K_PLD_S;
    end else if (op_code[7:6] == 2'b00 && op_code[3:2] == 2'b01) begin
      case (op_code[1:0])
        2'b00:   dec.kind = K_XINC;
        2'b01:   dec.kind = K_LD;
        2'b10:   dec.kind = K_XCH;
        default: dec.kind = K_XDEC;
      endcase
    end else if (op_code[7:4] == 4'h7) begin
      dec.kind = K_STORE;
    end else begin
      case (op_code)
        8'h4C: begin dec.kind = K_BCLR; dec.bsel = 2'd0; end
        8'h45: begin dec.kind = K_BCLR; dec.bsel = 2'd1; end
        8'h42: begin dec.kind = K_BCLR; dec.bsel = 2'd2; end
        8'h43: begin dec.kind = K_BCLR; dec.bsel = 2'd3; end
        8'h4D: begin dec.kind = K_BSET; dec.bsel = 2'd0; end
        8'h47: begin dec.kind = K_BSET; dec.bsel = 2'd1; end
        8'h46: begin dec.kind = K_BSET; dec.bsel = 2'd2; end
        8'h4B: begin dec.kind = K_BSET; dec.bsel = 2'd3; end
        8'h50: dec.kind = K_A2D;
        8'h4E: dec.kind = K_D2A;
        default: dec.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nptr_ram.sv
module nptr_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/nptr_breg.sv
module nptr_breg
  import nptr_pkg::*;
#(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned NIB_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  kind_e                    kind,
  input  logic [1:0]               rsel,
  input  logic [3:0]               imm,
  input  logic [6:0]               dir,
  input  logic [NIB_W-1:0]         a_in,
  output logic [ROW_W+NIB_W-1:0]   b_q
);

  localparam int unsigned PTR_W = ROW_W + NIB_W;

  logic [ROW_W-1:0] row, row_n;
  logic [NIB_W-1:0] dig, dig_n;
  logic             run_q, is_pld;

  assign row    = b_q[PTR_W-1:NIB_W];
  assign dig    = b_q[NIB_W-1:0];
  assign is_pld = (kind == K_PLD_S) || (kind == K_PLD_L);

  always_comb begin
    row_n = row;
    dig_n = dig;
    case (kind)
      K_LD, K_XCH: row_n = row ^ ROW_W'(rsel);
      K_XINC: begin
        row_n = row ^ ROW_W'(rsel);
        dig_n = dig + NIB_W'(1);
      end
      K_XDEC: begin
        row_n = row ^ ROW_W'(rsel);
        dig_n = dig - NIB_W'(1);
      end
      K_STORE: dig_n = dig + NIB_W'(1);
      K_PLD_S: if (!run_q) begin
        row_n = ROW_W'(rsel);
        dig_n = NIB_W'(imm) + NIB_W'(1);
      end
      K_PLD_L: if (!run_q) begin
        row_n = dir[6:4];
        dig_n = NIB_W'(dir[3:0]);
      end
      K_A2D:  dig_n = a_in;
      K_XROW: row_n = ROW_W'(a_in[1:0]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q   <= '0;
      run_q <= 1'b0;
    end else if (valid) begin
      b_q   <= {row_n, dig_n};
      run_q <= is_pld;
    end
  end

  a_r8_repeat_load_ignored: assert property (@(posedge clk) disable iff (rst)
    (valid && is_pld && run_q) |=> $stable(b_q));

  a_r8_idle_keeps_run: assert property (@(posedge clk) disable iff (rst)
    (!valid) |=> ($stable(b_q) && $stable(run_q)));

  a_r9_direct_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (valid && (kind == K_DXCH || kind == K_DLD)) |=> $stable(b_q));

endmodule

// File: rtl/nib_ptr_unit.sv
module nib_ptr_unit
  import nptr_pkg::*;
#(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned NIB_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  input  logic [7:0]             op_code,
  input  logic [7:0]             op_arg,
  input  logic [NIB_W-1:0]       a_in,
  output logic [NIB_W-1:0]       a_out,
  output logic                   a_load,
  output logic                   skip_req,
  output logic [ROW_W+NIB_W-1:0] b_out
);

  localparam int unsigned PTR_W = ROW_W + NIB_W;

  dec_t             dec;
  logic [PTR_W-1:0] b_q, ram_addr;
  logic [NIB_W-1:0] rdata, wdata, bmask, a_nxt;
  logic             wen, ld_nxt, skp_nxt, direct;

  nptr_decode u_dec (
    .op_code (op_code),
    .op_arg  (op_arg),
    .dec     (dec)
  );

  nptr_breg #(.ROW_W(ROW_W), .NIB_W(NIB_W)) u_breg (
    .clk   (clk),
    .rst   (rst),
    .valid (op_valid),
    .kind  (dec.kind),
    .rsel  (dec.rsel),
    .imm   (dec.imm),
    .dir   (dec.dir),
    .a_in  (a_in),
    .b_q   (b_q)
  );

  assign direct   = (dec.kind == K_DXCH) || (dec.kind == K_DLD);
  assign ram_addr = direct ? PTR_W'(dec.dir) : b_q;
  assign bmask    = NIB_W'(1) << dec.bsel;

  nptr_ram #(.AW(PTR_W), .DW(NIB_W)) u_ram (
    .clk   (clk),
    .we    (wen),
    .addr  (ram_addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_comb begin
    wen     = 1'b0;
    wdata   = a_in;
    a_nxt   = rdata;
    ld_nxt  = 1'b0;
    skp_nxt = 1'b0;
    case (dec.kind)
      K_LD, K_DLD: ld_nxt = 1'b1;
      K_XCH, K_DXCH: begin
        wen    = 1'b1;
        ld_nxt = 1'b1;
      end
      K_XINC: begin
        wen     = 1'b1;
        ld_nxt  = 1'b1;
        skp_nxt = (b_q[NIB_W-1:0] == '1);
      end
      K_XDEC: begin
        wen     = 1'b1;
        ld_nxt  = 1'b1;
        skp_nxt = (b_q[NIB_W-1:0] == '0);
      end
      K_STORE: begin
        wen   = 1'b1;
        wdata = NIB_W'(dec.imm);
      end
      K_BCLR: begin
        wen   = 1'b1;
        wdata = rdata & ~bmask;
      end
      K_BSET: begin
        wen   = 1'b1;
        wdata = rdata | bmask;
      end
      K_D2A: begin
        ld_nxt = 1'b1;
        a_nxt  = b_q[NIB_W-1:0];
      end
      K_XROW: begin
        ld_nxt = 1'b1;
        a_nxt  = NIB_W'(b_q[PTR_W-1:NIB_W]);
      end
      default: ;
    endcase
    if (!op_valid) begin
      wen     = 1'b0;
      ld_nxt  = 1'b0;
      skp_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out    <= '0;
      a_load   <= 1'b0;
      skip_req <= 1'b0;
    end else begin
      a_load   <= ld_nxt;
      skip_req <= skp_nxt;
      if (ld_nxt) a_out <= a_nxt;
    end
  end

  assign b_out = b_q;

  a_r4_inc_wrap_skip: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec.kind == K_XINC && b_out[NIB_W-1:0] == '1)
      |=> (skip_req && b_out[NIB_W-1:0] == '0));

  a_r5_dec_wrap_skip: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec.kind == K_XDEC && b_out[NIB_W-1:0] == '0)
      |=> (skip_req && b_out[NIB_W-1:0] == '1));

  a_r6_store_no_skip: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec.kind == K_STORE) |=> (!skip_req && !a_load));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!op_valid) |=> (!a_load && !skip_req && $stable(a_out)));

endmodule

// File: tb/nib_ptr_unit_test.sv
module nib_ptr_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 36;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [7:0] op_arg = 8'h00;
  logic [3:0] a_in = 4'h0;
  logic [3:0] a_out;
  logic       a_load, skip_req;
  logic [6:0] b_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_ptr_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .a_in(a_in), .a_out(a_out), .a_load(a_load),
    .skip_req(skip_req), .b_out(b_out)
  );

  // {req, op, arg, a_in, exp a_out, exp a_load, exp skip, exp pointer}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd7,  8'h33, 8'hA5, 4'h0, 4'h0, 1'b0, 1'b0, 7'h25}, // R7 long load
    {4'd8,  8'h1A, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 7'h25}, // R8 repeat ignored
    {4'd6,  8'h77, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 7'h26}, // R6
    {4'd6,  8'h7C, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 7'h27}, // R6
    {4'd7,  8'h1D, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 7'h1E}, // R7 short load
    {4'd8,  8'h33, 8'hA5, 4'h0, 4'h0, 1'b0, 1'b0, 7'h1E}, // R8 repeat ignored
    {4'd6,  8'h73, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 7'h1F}, // R6
    {4'd6,  8'h79, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 7'h10}, // R6 wrap, no skip
    {4'd7,  8'h33, 8'h9F, 4'h0, 4'h0, 1'b0, 1'b0, 7'h1F}, // R7
    {4'd4,  8'h14, 8'h00, 4'h2, 4'h9, 1'b1, 1'b1, 7'h00}, // R4 wrap skip + row xor
    {4'd7,  8'h33, 8'hA5, 4'h0, 4'h9, 1'b0, 1'b0, 7'h25}, // R7
    {4'd5,  8'h27, 8'h00, 4'h4, 4'h7, 1'b1, 1'b0, 7'h04}, // R5 no wrap
    {4'd9,  8'h23, 8'h9F, 4'h6, 4'h2, 1'b1, 1'b0, 7'h04}, // R9 direct exchange
    {4'd9,  8'h23, 8'h1E, 4'h0, 4'h3, 1'b1, 1'b0, 7'h04}, // R9 direct load
    {4'd9,  8'h23, 8'h25, 4'h0, 4'h4, 1'b1, 1'b0, 7'h04}, // R9
    {4'd7,  8'h33, 8'h90, 4'h0, 4'h4, 1'b0, 1'b0, 7'h10}, // R7
    {4'd6,  8'h7B, 8'h00, 4'h0, 4'h4, 1'b0, 1'b0, 7'h11}, // R6
    {4'd7,  8'h33, 8'h90, 4'h0, 4'h4, 1'b0, 1'b0, 7'h10}, // R7
    {4'd5,  8'h37, 8'h00, 4'h8, 4'hB, 1'b1, 1'b1, 7'h2F}, // R5 wrap skip + row xor
    {4'd7,  8'h33, 8'h90, 4'h0, 4'hB, 1'b0, 1'b0, 7'h10}, // R7
    {4'd3,  8'h06, 8'h00, 4'h5, 4'h8, 1'b1, 1'b0, 7'h10}, // R3
    {4'd10, 8'h4C, 8'h00, 4'h0, 4'h8, 1'b0, 1'b0, 7'h10}, // R10 clear bit0
    {4'd10, 8'h4B, 8'h00, 4'h0, 4'h8, 1'b0, 1'b0, 7'h10}, // R10 set bit3
    {4'd10, 8'h47, 8'h00, 4'h0, 4'h8, 1'b0, 1'b0, 7'h10}, // R10 set bit1
    {4'd10, 8'h42, 8'h00, 4'h0, 4'h8, 1'b0, 1'b0, 7'h10}, // R10 clear bit2
    {4'd2,  8'h05, 8'h00, 4'h0, 4'hA, 1'b1, 1'b0, 7'h10}, // R2 reads 0xA
    {4'd11, 8'h4E, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0, 7'h10}, // R11 digit to A
    {4'd11, 8'h50, 8'h00, 4'hD, 4'h0, 1'b0, 1'b0, 7'h1D}, // R11 A to digit
    {4'd12, 8'h12, 8'h00, 4'h6, 4'h1, 1'b1, 1'b0, 7'h2D}, // R12
    {4'd12, 8'h12, 8'h00, 4'hF, 4'h2, 1'b1, 1'b0, 7'h3D}, // R12
    {4'd7,  8'h33, 8'hF1, 4'h0, 4'h2, 1'b0, 1'b0, 7'h71}, // R7 top row
    {4'd6,  8'h7F, 8'h00, 4'h0, 4'h2, 1'b0, 1'b0, 7'h72}, // R6
    {4'd7,  8'h33, 8'hF1, 4'h0, 4'h2, 1'b0, 1'b0, 7'h71}, // R7
    {4'd10, 8'h43, 8'h00, 4'h0, 4'h2, 1'b0, 1'b0, 7'h71}, // R10 clear bit3
    {4'd10, 8'h05, 8'h00, 4'h0, 4'h7, 1'b1, 1'b0, 7'h71}, // R10 readback 7
    {4'd2,  8'h35, 8'h00, 4'h0, 4'h7, 1'b1, 1'b0, 7'h41}  // R2 row 7^3
  };

  task automatic check(input string req, input logic [3:0] ea, input logic el,
                       input logic es, input logic [6:0] eb);
    total++;
    if (a_out !== ea || a_load !== el || skip_req !== es || b_out !== eb) begin
      bad++;
      $display("FAIL %s: got a=%h ld=%b sk=%b b=%h, expected a=%h ld=%b sk=%b b=%h",
               req, a_out, a_load, skip_req, b_out, ea, el, es, eb);
    end
  endtask

  task automatic issue(input logic v, input logic [7:0] op, input logic [7:0] arg,
                       input logic [3:0] ain);
    op_valid = v;
    op_code  = op;
    op_arg   = arg;
    a_in     = ain;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got no end, expected end of run");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 4'h0, 1'b0, 1'b0, 7'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      issue(1'b1, v[32:25], v[24:17], v[16:13]);
      check($sformatf("R%0d vector %0d", v[36:33], i), v[12:9], v[8], v[7], v[6:0]);
    end

    // R1: reset mid-run clears pointer and accumulator output
    op_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", 4'h0, 1'b0, 1'b0, 7'h00);
    // R1: first load after reset takes effect
    issue(1'b1, 8'h33, 8'hA5, 4'h0);
    check("R1 first load after reset", 4'h0, 1'b0, 1'b0, 7'h25);
    // R13: idle with a load code present changes nothing
    issue(1'b0, 8'h1A, 8'h00, 4'h0);
    check("R13 idle cycle", 4'h0, 1'b0, 1'b0, 7'h25);
    // R8: idle does not end the run of loads
    issue(1'b1, 8'h1A, 8'h00, 4'h0);
    check("R8 run across idle", 4'h0, 1'b0, 1'b0, 7'h25);
    // R8: a foreign instruction ends the run
    issue(1'b1, 8'h00, 8'h00, 4'h0);
    check("R8 foreign op keeps pointer", 4'h0, 1'b0, 1'b0, 7'h25);
    issue(1'b1, 8'h1A, 8'h00, 4'h0);
    check("R8 load after foreign op", 4'h0, 1'b0, 1'b0, 7'h1B);
    // R7: 0x33 with second-byte bit 7 clear is not a pointer load
    issue(1'b1, 8'h33, 8'h25, 4'h0);
    check("R7 0x33 without load bit", 4'h0, 1'b0, 1'b0, 7'h1B);
    // R13: result pulses last one cycle, a_out holds
    issue(1'b1, 8'h7E, 8'h00, 4'h0);
    issue(1'b1, 8'h33, 8'h9B, 4'h0);
    issue(1'b1, 8'h15, 8'h00, 4'h0);
    check("R2 load with row flip", 4'hE, 1'b1, 1'b0, 7'h0B);
    issue(1'b0, 8'h15, 8'h00, 4'h0);
    check("R13 pulse ends, value held", 4'hE, 1'b0, 1'b0, 7'h0B);

    finish_run();
  end

endmodule